// File: doc/BRIEF.md
# Segment Descriptor Shadow Loader

This block holds the hidden half of one segment register in a processor running with descriptor-based memory protection. Software writes a 16-bit selector. The block splits the selector into its fields and picks the base and limit of the global or the local descriptor table. It then reads the 8-byte descriptor for that index through a simple read port with 32-bit addresses and 16-bit data. Base, limit and access rights from the descriptor are latched into a shadow cache. Memory is not read again until the next selector write.

After the load, every access presents an offset. The block returns the linear address (cached base plus offset) one cycle later, or flags a protection fault. A fault is raised when the offset is past the cached limit or when the segment holds the null selector. The local table's base and limit come in as inputs. In a full design they come from a second instance of this block whose selectors always index the global table.

Top module: `seg_shadow_loader`

## Requirements
- R1: A selector write places the descriptor index in bits 15:3, the table-select bit in bit 2 and the requested privilege in bits 1:0. After a successful or null load, `sel_o` returns the written selector unchanged.
- R2: A table-select value of 0 uses `gdt_base_i`/`gdt_limit_i` and a value of 1 uses `ldt_base_i`/`ldt_limit_i`. The descriptor starts at table base + index*8.
- R3: A load issues exactly four 16-bit reads, at descriptor address +0, +2, +4 and +6 in that order. Only one read is outstanding at a time. `mem_rd_o` and `mem_addr_o` stay fixed until `mem_ack_i`, and `mem_rdata_i` is taken in the ack cycle.
- R4: The descriptor is decoded little-endian. Word +0 is the limit. Word +2 is base bits 15:0. The low byte of word +4 is base bits 23:16 and its high byte is the access-rights byte shown on `rights_o`. Word +6 is read and discarded.
- R5: A global selector with index 0 (any privilege bits) is the null selector. It causes no memory read. It sets `rights_o` to 0 and makes every later access fault. The reset state behaves the same way, with `sel_o` = 0.
- R6: When index*8+7 exceeds the chosen table's limit, the load is refused. `load_fault_o` pulses in the cycle after the write, no read is issued, and `sel_o`, `rights_o` and the translation stay as they were.
- R7: `busy_o` is high from the cycle after an accepted load until the last read is acknowledged. While busy, selector writes are dropped and access requests get no response.
- R8: An access accepted while not busy raises `lin_valid_o` one cycle later. `lin_addr_o` is then the cached 24-bit base plus the zero-extended offset, and `acc_fault_o` is 0 when the offset is at most the limit.
- R9: An access whose offset is greater than the cached limit returns `lin_valid_o` together with `acc_fault_o` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gdt_base_i | input | 32 | Global table base address |
| gdt_limit_i | input | 16 | Global table byte limit |
| ldt_base_i | input | 32 | Local table base address |
| ldt_limit_i | input | 16 | Local table byte limit |
| sel_we_i | input | 1 | Selector write strobe |
| sel_wdata_i | input | 16 | Selector value written |
| sel_o | output | 16 | Currently loaded selector |
| busy_o | output | 1 | Descriptor fetch in progress |
| load_fault_o | output | 1 | Pulse: selector past table limit |
| mem_rd_o | output | 1 | Descriptor read request |
| mem_addr_o | output | 32 | Descriptor read byte address |
| mem_ack_i | input | 1 | Read data valid |
| mem_rdata_i | input | 16 | Read data word |
| acc_req_i | input | 1 | Access request |
| acc_ofs_i | input | 32 | Access offset |
| lin_valid_o | output | 1 | Translation result valid |
| lin_addr_o | output | 32 | Linear address |
| acc_fault_o | output | 1 | Protection fault on this access |
| rights_o | output | 8 | Cached access-rights byte |

## Verification
The bench keeps the default 32-bit address and offset widths. It uses small tables: the global table limit is 3FH, giving eight descriptors, and the local table limit is 1FH, giving four, with the local base deliberately off a 16-byte boundary. With tables this small, a sweep over indices 0 to 9 in both tables reaches every in-table descriptor, the null entry and several indices past the limit. The descriptor contents are computed from index and table, and one limit is set to FFFFH. Each load is followed by accesses at offset 0, at the limit and one past it.

// File: rtl/segld_pkg.sv
package segld_pkg;
  localparam int SEL_W      = 16;
  localparam int IDX_W      = 13;
  localparam int LIM_W      = 16;
  localparam int BASE_W     = 24;
  localparam int AR_W       = 8;
  localparam int WORD_W     = 16;
  localparam int DESC_WORDS = 4;
  localparam int DESC_SHIFT = 3;

  typedef struct packed {
    logic [IDX_W-1:0] idx;
    logic             ti;
    logic [1:0]       rpl;
  } sel_t;

  typedef enum logic {F_IDLE, F_READ} fstate_t;

  // byte offset of a descriptor inside its table
  function automatic logic [LIM_W-1:0] desc_offset(input logic [IDX_W-1:0] idx);
    return {idx, {DESC_SHIFT{1'b0}}};
  endfunction

  // whole descriptor (last byte included) lies inside the table
  function automatic logic fits_table(input logic [IDX_W-1:0] idx,
                                      input logic [LIM_W-1:0] tlim);
    return {idx, {DESC_SHIFT{1'b1}}} <= tlim;
  endfunction
endpackage

// File: rtl/segld_sel_decode.sv
module segld_sel_decode
  import segld_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              ti_i,
  input  logic [ADDR_W-1:0] gdt_base_i,
  input  logic [LIM_W-1:0]  gdt_limit_i,
  input  logic [ADDR_W-1:0] ldt_base_i,
  input  logic [LIM_W-1:0]  ldt_limit_i,
  output logic [ADDR_W-1:0] desc_addr_o,
  output logic              is_null_o,
  output logic              fits_o
);
  logic [ADDR_W-1:0] tbase;
  logic [LIM_W-1:0]  tlim;

  always_comb begin
    tbase       = ti_i ? ldt_base_i : gdt_base_i;
    tlim        = ti_i ? ldt_limit_i : gdt_limit_i;
    desc_addr_o = tbase + ADDR_W'(desc_offset(idx_i));
    is_null_o   = !ti_i && (idx_i == '0);
    fits_o      = fits_table(idx_i, tlim);
  end
endmodule

// File: rtl/segld_fetch.sv
module segld_fetch
  import segld_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              mem_rd_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_ack_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic [WORD_W-1:0] w_limit_o,
  output logic [WORD_W-1:0] w_base_lo_o,
  output logic [WORD_W-1:0] w_hi_o
);
  localparam int CNT_W    = $clog2(DESC_WORDS);
  localparam int LAST_IDX = DESC_WORDS - 1;

  fstate_t           state;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] daddr;
  logic              last_word;

  assign busy_o     = (state == F_READ);
  assign mem_rd_o   = busy_o;
  assign mem_addr_o = daddr + ADDR_W'({cnt, 1'b0});
  assign last_word  = (cnt == CNT_W'(LAST_IDX));
  assign done_o     = busy_o && mem_ack_i && last_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= F_IDLE;
      cnt         <= '0;
      daddr       <= '0;
      w_limit_o   <= '0;
      w_base_lo_o <= '0;
      w_hi_o      <= '0;
    end else if (state == F_IDLE) begin
      if (start_i) begin
        state <= F_READ;
        daddr <= start_addr_i;
        cnt   <= '0;
      end
    end else if (mem_ack_i) begin
      case (cnt)
        CNT_W'(0): w_limit_o   <= mem_rdata_i;
        CNT_W'(1): w_base_lo_o <= mem_rdata_i;
        CNT_W'(2): w_hi_o      <= mem_rdata_i;
        default: ;
      endcase
      if (last_word) state <= F_IDLE;
      else           cnt   <= cnt + CNT_W'(1);
    end
  end

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_o && !mem_ack_i) |=> (mem_rd_o && $stable(mem_addr_o))); // R3
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_o && mem_ack_i && !last_word) |=>
      (mem_rd_o && mem_addr_o == $past(mem_addr_o) + ADDR_W'(2))); // R3
endmodule

// File: rtl/segld_xlate.sv
module segld_xlate
  import segld_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_req_i,
  input  logic [OFS_W-1:0]  acc_ofs_i,
  input  logic              busy_i,
  input  logic              seg_null_i,
  input  logic [BASE_W-1:0] seg_base_i,
  input  logic [LIM_W-1:0]  seg_limit_i,
  output logic              lin_valid_o,
  output logic [ADDR_W-1:0] lin_addr_o,
  output logic              acc_fault_o
);
  logic take;
  logic over_limit;

  function automatic logic [ADDR_W-1:0] lin_of(input logic [BASE_W-1:0] b,
                                               input logic [OFS_W-1:0]  o);
    return ADDR_W'(b) + ADDR_W'(o);
  endfunction

  assign take       = acc_req_i && !busy_i;
  assign over_limit = acc_ofs_i > OFS_W'(seg_limit_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lin_valid_o <= 1'b0;
      lin_addr_o  <= '0;
      acc_fault_o <= 1'b0;
    end else begin
      lin_valid_o <= take;
      if (take) begin
        lin_addr_o  <= lin_of(seg_base_i, acc_ofs_i);
        acc_fault_o <= seg_null_i || over_limit;
      end else begin
        acc_fault_o <= 1'b0;
      end
    end
  end

  AST_LIN_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_req_i && !busy_i) |=> lin_valid_o); // R8
  AST_STALL_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_req_i && busy_i) |=> !lin_valid_o); // R7
endmodule

// File: rtl/seg_shadow_loader.sv
module seg_shadow_loader
  import segld_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] gdt_base_i,
  input  logic [LIM_W-1:0]  gdt_limit_i,
  input  logic [ADDR_W-1:0] ldt_base_i,
  input  logic [LIM_W-1:0]  ldt_limit_i,
  input  logic              sel_we_i,
  input  logic [SEL_W-1:0]  sel_wdata_i,
  output logic [SEL_W-1:0]  sel_o,
  output logic              busy_o,
  output logic              load_fault_o,
  output logic              mem_rd_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_ack_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  input  logic              acc_req_i,
  input  logic [OFS_W-1:0]  acc_ofs_i,
  output logic              lin_valid_o,
  output logic [ADDR_W-1:0] lin_addr_o,
  output logic              acc_fault_o,
  output logic [AR_W-1:0]   rights_o
);
  sel_t              wsel;
  logic [ADDR_W-1:0] desc_addr;
  logic              is_null, fits;
  logic              accept, fetch_start, fetch_done;
  logic [WORD_W-1:0] w_limit, w_base_lo, w_hi;
  logic [SEL_W-1:0]  pend_sel;
  logic              seg_null;
  logic [BASE_W-1:0] seg_base;
  logic [LIM_W-1:0]  seg_limit;

  assign wsel        = sel_t'(sel_wdata_i);
  assign accept      = sel_we_i && !busy_o;
  assign fetch_start = accept && !is_null && fits;

  segld_sel_decode #(.ADDR_W(ADDR_W)) u_dec (
    .idx_i       (wsel.idx),
    .ti_i        (wsel.ti),
    .gdt_base_i  (gdt_base_i),
    .gdt_limit_i (gdt_limit_i),
    .ldt_base_i  (ldt_base_i),
    .ldt_limit_i (ldt_limit_i),
    .desc_addr_o (desc_addr),
    .is_null_o   (is_null),
    .fits_o      (fits)
  );

  segld_fetch #(.ADDR_W(ADDR_W)) u_fetch (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (fetch_start),
    .start_addr_i (desc_addr),
    .busy_o       (busy_o),
    .done_o       (fetch_done),
    .mem_rd_o     (mem_rd_o),
    .mem_addr_o   (mem_addr_o),
    .mem_ack_i    (mem_ack_i),
    .mem_rdata_i  (mem_rdata_i),
    .w_limit_o    (w_limit),
    .w_base_lo_o  (w_base_lo),
    .w_hi_o       (w_hi)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_o        <= '0;
      pend_sel     <= '0;
      seg_null     <= 1'b1;
      seg_base     <= '0;
      seg_limit    <= '0;
      rights_o     <= '0;
      load_fault_o <= 1'b0;
    end else begin
      load_fault_o <= accept && !is_null && !fits;
      if (accept && is_null) begin
        sel_o    <= sel_wdata_i;
        seg_null <= 1'b1;
        rights_o <= '0;
      end
      if (fetch_start) pend_sel <= sel_wdata_i;
      if (fetch_done) begin
        sel_o     <= pend_sel;
        seg_null  <= 1'b0;
        seg_limit <= w_limit;
        seg_base  <= {w_hi[7:0], w_base_lo};
        rights_o  <= w_hi[WORD_W-1 -: AR_W];
      end
    end
  end

  segld_xlate #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_xlate (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_req_i   (acc_req_i),
    .acc_ofs_i   (acc_ofs_i),
    .busy_i      (busy_o),
    .seg_null_i  (seg_null),
    .seg_base_i  (seg_base),
    .seg_limit_i (seg_limit),
    .lin_valid_o (lin_valid_o),
    .lin_addr_o  (lin_addr_o),
    .acc_fault_o (acc_fault_o)
  );

  AST_NULL_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && is_null) |=> !mem_rd_o); // R5
  AST_LOADFAULT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    load_fault_o |-> (!busy_o && !mem_rd_o)); // R6
  AST_FAULT_HAS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fault_o |-> lin_valid_o); // R9
endmodule

// File: tb/seg_shadow_loader_tb.sv
`timescale 1ns/1ps
module seg_shadow_loader_tb_top;
  localparam logic [31:0] GBASE = 32'h0000_1000;
  localparam logic [15:0] GLIM  = 16'h003F;
  localparam logic [31:0] LBASE = 32'h0000_2008;
  localparam logic [15:0] LLIM  = 16'h001F;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_we = 1'b0;
  logic [15:0] sel_wdata = '0;
  logic [15:0] sel_o;
  logic        busy, load_fault, mem_rd, mem_ack = 1'b0;
  logic [31:0] mem_addr;
  logic [15:0] mem_rdata = '0;
  logic        acc_req = 1'b0;
  logic [31:0] acc_ofs = '0;
  logic        lin_valid, acc_fault;
  logic [31:0] lin_addr;
  logic [7:0]  rights;

  int checks = 0;
  int failures = 0;
  int rd_total = 0;
  logic [31:0] rd_log [0:15];

  always #2.5 clk = ~clk;

  seg_shadow_loader dut_i (
    .clk(clk), .rst_n(rst_n),
    .gdt_base_i(GBASE), .gdt_limit_i(GLIM), .ldt_base_i(LBASE), .ldt_limit_i(LLIM),
    .sel_we_i(sel_we), .sel_wdata_i(sel_wdata), .sel_o(sel_o),
    .busy_o(busy), .load_fault_o(load_fault),
    .mem_rd_o(mem_rd), .mem_addr_o(mem_addr), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .acc_req_i(acc_req), .acc_ofs_i(acc_ofs),
    .lin_valid_o(lin_valid), .lin_addr_o(lin_addr), .acc_fault_o(acc_fault),
    .rights_o(rights)
  );

  function automatic logic [15:0] d_lim(int t, int i);
    if (i == 5) return 16'hFFFF;
    return 16'(16'h0123 * (i + 1) + t);
  endfunction
  function automatic logic [23:0] d_base(int t, int i);
    return 24'(24'h100000 + t * 24'h080000 + i * 24'h011111);
  endfunction
  function automatic logic [7:0] d_ar(int t, int i);
    return 8'(8'h80 + t * 16 + i);
  endfunction
  function automatic logic [15:0] mem_word(logic [31:0] a);
    int t, rel, i, w;
    logic [23:0] b;
    if (a >= GBASE && a < GBASE + 32'h40) begin t = 0; rel = int'(a - GBASE); end
    else if (a >= LBASE && a < LBASE + 32'h20) begin t = 1; rel = int'(a - LBASE); end
    else return 16'hDEAD;
    i = rel / 8; w = (rel / 2) % 4; b = d_base(t, i);
    case (w)
      0: return d_lim(t, i);
      1: return b[15:0];
      2: return {d_ar(t, i), b[23:16]};
      default: return 16'hA5A5;
    endcase
  endfunction

  always @(posedge clk) begin
    if (mem_ack) mem_ack <= 1'b0;
    else if (mem_rd) begin
      mem_ack   <= 1'b1;
      mem_rdata <= mem_word(mem_addr);
      rd_log[rd_total % 16] <= mem_addr;
      rd_total  <= rd_total + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // returns fault pulse seen, busy seen in first cycle, reads issued
  task automatic load(input logic [15:0] s, output bit lf, output bit bz, output int nrd, output int first);
    @(negedge clk);
    first = rd_total;
    sel_we = 1'b1; sel_wdata = s;
    @(negedge clk);
    sel_we = 1'b0;
    lf = load_fault; bz = busy;
    for (int k = 0; k < 40 && busy; k++) @(negedge clk);
    nrd = rd_total - first;
  endtask

  task automatic access(input logic [31:0] o, output bit v, output logic [31:0] a, output bit f);
    @(negedge clk);
    acc_req = 1'b1; acc_ofs = o;
    @(negedge clk);
    acc_req = 1'b0;
    v = lin_valid; a = lin_addr; f = acc_fault;
  endtask

  initial begin
    #(5ns * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    bit lf, bz, v, f;
    int nrd, first;
    logic [31:0] a;
    logic [15:0] m_sel = '0;
    logic [23:0] m_base = '0;
    logic [15:0] m_lim = '0;
    logic [7:0]  m_ar = '0;
    bit          m_null = 1'b1;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sel_o == 16'h0 && !busy && !load_fault && !lin_valid, "R5 reset state", {16'h0, sel_o}, 32'h0);
    access(32'h0, v, a, f);
    chk(v && f, "R5 access after reset faults", {30'h0, v, f}, 32'h3);

    for (int t = 0; t < 2; t++) begin
      for (int i = 0; i < 10; i++) begin
        logic [15:0] s;
        bit isnull, fitsb;
        logic [31:0] daddr;
        s = {13'(i), 1'(t), 2'(i % 4)};
        isnull = (t == 0 && i == 0);
        fitsb = (i * 8 + 7) <= int'(t ? LLIM : GLIM);
        daddr = (t ? LBASE : GBASE) + 32'(i * 8);
        load(s, lf, bz, nrd, first);
        if (isnull) begin
          chk(nrd == 0 && !lf, "R5 null load no read", 32'(nrd), 32'h0);
          chk(sel_o == s, "R1 null selector kept", {16'h0, sel_o}, {16'h0, s});
          chk(rights == 8'h00, "R5 null rights cleared", {24'h0, rights}, 32'h0);
          access(32'h0, v, a, f);
          chk(v && f, "R5 null access faults", {30'h0, v, f}, 32'h3);
          m_sel = s; m_null = 1'b1; m_ar = 8'h00;
        end else if (!fitsb) begin
          chk(lf && nrd == 0, "R6 beyond limit refused", {31'h0, lf}, 32'h1);
          chk(sel_o == m_sel, "R6 selector kept", {16'h0, sel_o}, {16'h0, m_sel});
          chk(rights == m_ar, "R6 rights kept", {24'h0, rights}, {24'h0, m_ar});
          access(32'h0, v, a, f);
          if (m_null) chk(v && f, "R6 old null kept", {30'h0, v, f}, 32'h3);
          else chk(v && !f && a == {8'h0, m_base}, "R6 old base kept", a, {8'h0, m_base});
        end else begin
          chk(bz && !lf, "R7 busy after accepted load", {30'h0, bz, lf}, 32'h2);
          chk(nrd == 4, "R3 four reads", 32'(nrd), 32'h4);
          for (int k = 0; k < 4; k++)
            chk(rd_log[(first + k) % 16] == daddr + 32'(2 * k), "R2 R3 read address order",
                rd_log[(first + k) % 16], daddr + 32'(2 * k));
          m_sel = s; m_null = 1'b0; m_base = d_base(t, i); m_lim = d_lim(t, i); m_ar = d_ar(t, i);
          chk(sel_o == s, "R1 selector loaded", {16'h0, sel_o}, {16'h0, s});
          chk(rights == m_ar, "R4 rights byte", {24'h0, rights}, {24'h0, m_ar});
          access(32'h0, v, a, f);
          chk(v && !f && a == {8'h0, m_base}, "R8 R4 base at offset 0", a, {8'h0, m_base});
          access({16'h0, m_lim}, v, a, f);
          chk(v && !f && a == {8'h0, m_base} + {16'h0, m_lim}, "R8 last byte at limit",
              a, {8'h0, m_base} + {16'h0, m_lim});
          access({16'h0, m_lim} + 32'h1, v, a, f);
          chk(v && f, "R9 limit plus one faults", {30'h0, v, f}, 32'h3);
        end
      end
    end

    // R7: writes and accesses while busy are dropped
    @(negedge clk);
    sel_we = 1'b1; sel_wdata = 16'h000C;           // local index 1
    @(negedge clk);
    sel_wdata = 16'h0010;                           // global index 2, during busy
    acc_req = 1'b1; acc_ofs = 32'h0;
    chk(busy, "R7 busy during fetch", {31'h0, busy}, 32'h1);
    @(negedge clk);
    sel_we = 1'b0; acc_req = 1'b0;
    chk(!lin_valid, "R7 stalled access no result", {31'h0, lin_valid}, 32'h0);
    for (int k = 0; k < 40 && busy; k++) @(negedge clk);
    chk(sel_o == 16'h000C, "R7 write during busy dropped", {16'h0, sel_o}, 32'h000C);
    access(32'h0, v, a, f);
    chk(v && !f && a == {8'h0, d_base(1, 1)}, "R2 local index 1 base", a, {8'h0, d_base(1, 1)});

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule